// File: doc/BRIEF.md
# Prioritized I/O Interrupt Acknowledge Arbiter

This block sits between a processor's interrupt-acknowledge instruction and a set of I/O subsystems (processors, controllers, devices), each of which may hold one pending interrupt. A subsystem raises its interrupt with a one-cycle pulse and presents a status byte at the same time. The block stores the request until it is acknowledged.

When the processor issues an acknowledge, the block picks one pending subsystem. It uses a priority list fixed per installation, which maps rank to port index, so priority does not depend on which port a subsystem is wired to. The chosen subsystem answers with a word that holds its status and its own unit address, and its pending request is dropped. The request carries no source address: the address reaches the processor only in the reply.

The block checks the selection field of the acknowledge address and returns a condition code. It asks for a write of the reply into the destination register only when the register field of the instruction is nonzero.

Top module: `io_intack_arbiter`

## Requirements
- R1: After reset, `pend_o` is all zero, and `rsp_valid_o` and `reg_we_o` are low.
- R2: A pulse on `raise_i[i]` sets `pend_o[i]` at the next clock edge and captures that port's status byte from `raise_stat_i[i*8 +: 8]`.
- R3: An acknowledge is served by the pending port that comes first in the rank list. The default list, highest rank first, is ports 2, 0, 3, 1. Exactly one port is served per acknowledge.
- R4: The reply word has the status byte in bits [31:24], zeros in bits [23:8], and in bits [7:0] the unit address of the serving port. The default unit address of port i is 0x40+i. The address is not an input of the acknowledge.
- R5: The served port's pending flag is clear from the edge that registers the acknowledge. Every other flag is unchanged.
- R6: A nonzero `ack_sel_i` (the 6-bit selection field, standard value 000000) gives `cc_o`=2'b11, no register write and no change to any pending flag.
- R7: When the register field `ack_ridx_i` is 0, an acknowledge with a pending port still sets `cc_o`=2'b01 and still clears the flag, but `reg_we_o` stays low.
- R8: When `ack_ridx_i` is nonzero and a port is served, `reg_we_o` is high, `reg_idx_o` equals `ack_ridx_i`, and `reg_wdata_o` carries the reply word.
- R9: A standard acknowledge with nothing pending gives `cc_o`=2'b00 and `reg_we_o` low.
- R10: `rsp_valid_o` is high for exactly the one cycle after each cycle in which `ack_valid_i` is high. In that cycle `cc_o`, `reg_we_o`, `reg_idx_o` and `reg_wdata_o` are valid.
- R11: If a port is raised in the same cycle in which it is served, it stays pending, and its new status byte replaces the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_i | input | N | One-cycle interrupt request per port |
| raise_stat_i | input | N*STAT_W | Status byte per port, captured with the raise |
| ack_valid_i | input | 1 | Acknowledge instruction issued this cycle |
| ack_sel_i | input | SEL_W | Selection field of the acknowledge address |
| ack_ridx_i | input | RIDX_W | Destination register field |
| rsp_valid_o | output | 1 | Reply and condition code valid |
| cc_o | output | 2 | 00 none pending, 01 acknowledged, 11 selection not recognized |
| reg_we_o | output | 1 | Write the reply into register `reg_idx_o` |
| reg_idx_o | output | RIDX_W | Destination register index |
| reg_wdata_o | output | WORD_W | Reply word |
| pend_o | output | N | Pending flag per port |

## Verification
A wrong rank decode or a corrupt pending flag shows up in the first reply that follows: the reply carries the wrong unit address, or the next acknowledge finds a flag set or clear that should not be. The sweep covers every nonempty pending mask. For each mask it drains the ports one acknowledge at a time, so a bad pick shows within one acknowledge, and a lost or extra flag shows by the closing empty acknowledge at the latest. Selection and register-field errors show in the same cycle as `rsp_valid_o`, through `cc_o` and `reg_we_o`.

// File: rtl/intack_pkg.sv
// Package: shared condition-code encoding for the interrupt-acknowledge arbiter.
// Assumes: two-bit condition code as seen by the processor.
package intack_pkg;
    typedef enum logic [1:0] {
        CC_NONE = 2'b00,
        CC_ACK  = 2'b01,
        CC_RSVD = 2'b11
    } cc_e;
endpackage

// File: rtl/intack_pending.sv
// Module: intack_pending
// Holds one pending flag and one status byte per port.
// Assumes: clr_i is one-hot or zero. A raise in the same cycle as a clear wins.
module intack_pending #(
    parameter int N      = 4,
    parameter int STAT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        raise_i,
    input  logic [N*STAT_W-1:0] stat_i,
    input  logic [N-1:0]        clr_i,
    output logic [N-1:0]        pend_o,
    output logic [N*STAT_W-1:0] stat_o
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic              pend_q;
        logic [STAT_W-1:0] stat_q;

        // Pending flag: set on raise, clear on acknowledge, raise has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)             pend_q <= 1'b0;
            else if (raise_i[i])    pend_q <= 1'b1;
            else if (clr_i[i])      pend_q <= 1'b0;
        end

        // Status byte: captured whenever the port raises.
        always_ff @(posedge clk) begin
            if (!rst_n)             stat_q <= '0;
            else if (raise_i[i])    stat_q <= stat_i[i*STAT_W +: STAT_W];
        end

        assign pend_o[i]                   = pend_q;
        assign stat_o[i*STAT_W +: STAT_W]  = stat_q;
    end
endmodule

// File: rtl/intack_prio_pick.sv
// Module: intack_prio_pick
// Picks the pending port with the best rank, using a rank-to-port map.
// Assumes: RANK_MAP lists every port exactly once; rank 0 is highest.
module intack_prio_pick #(
    parameter int                   N        = 4,
    parameter int                   IDXW     = 2,
    parameter logic [N*IDXW-1:0]    RANK_MAP = '0
) (
    input  logic [N-1:0]    pend_i,
    output logic [N-1:0]    grant_o,
    output logic            any_o,
    output logic [IDXW-1:0] idx_o
);
    logic [N-1:0] hit;

    // Reorder the pending flags into rank order.
    for (genvar r = 0; r < N; r++) begin : g_rank
        localparam logic [IDXW-1:0] PORT = RANK_MAP[r*IDXW +: IDXW];
        assign hit[r] = pend_i[PORT];
    end

    // Walk ranks from lowest to highest so the best rank is written last.
    always_comb begin
        idx_o = '0;
        for (int r = N - 1; r >= 0; r--) begin
            if (hit[r]) idx_o = RANK_MAP[r*IDXW +: IDXW];
        end
    end

    // One-hot grant for the selected port.
    always_comb begin
        grant_o = '0;
        if (any_o) grant_o[idx_o] = 1'b1;
    end

    assign any_o = |hit;
endmodule

// File: rtl/intack_resp.sv
// Module: intack_resp
// Registers the condition code, the write request and the reply word one cycle after an acknowledge.
// Assumes: idx_i is valid when any_i is high.
module intack_resp
    import intack_pkg::*;
#(
    parameter int                  N        = 4,
    parameter int                  IDXW     = 2,
    parameter int                  STAT_W   = 8,
    parameter int                  ADDR_W   = 8,
    parameter int                  RIDX_W   = 4,
    parameter int                  WORD_W   = 32,
    parameter logic [N*ADDR_W-1:0] SRC_ADDR = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ack_valid_i,
    input  logic                sel_ok_i,
    input  logic                any_i,
    input  logic [IDXW-1:0]     idx_i,
    input  logic [N*STAT_W-1:0] stat_all_i,
    input  logic [RIDX_W-1:0]   ridx_i,
    output logic                rsp_valid_o,
    output logic [1:0]          cc_o,
    output logic                reg_we_o,
    output logic [RIDX_W-1:0]   reg_idx_o,
    output logic [WORD_W-1:0]   reg_wdata_o
);
    logic [WORD_W-1:0] word_d;
    cc_e               cc_d;
    logic              we_d;

    // Build the reply word from the chosen port's status and unit address.
    always_comb begin
        word_d = '0;
        word_d[WORD_W-1 -: STAT_W] = stat_all_i[idx_i*STAT_W +: STAT_W];
        word_d[ADDR_W-1:0]         = SRC_ADDR[idx_i*ADDR_W +: ADDR_W];
    end

    // Condition code and write request from the selection, pending and register fields.
    always_comb begin
        if (!sel_ok_i)   cc_d = CC_RSVD;
        else if (any_i)  cc_d = CC_ACK;
        else             cc_d = CC_NONE;
        we_d = ack_valid_i && sel_ok_i && any_i && (ridx_i != '0);
    end

    // Response registers, valid for one cycle after each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            cc_o        <= CC_NONE;
            reg_we_o    <= 1'b0;
            reg_idx_o   <= '0;
            reg_wdata_o <= '0;
        end else begin
            rsp_valid_o <= ack_valid_i;
            reg_we_o    <= we_d;
            if (ack_valid_i) begin
                cc_o        <= cc_d;
                reg_idx_o   <= ridx_i;
                reg_wdata_o <= word_d;
            end
        end
    end
endmodule

// File: rtl/io_intack_arbiter.sv
// Module: io_intack_arbiter (top)
// Arbitrates interrupt-acknowledge instructions among N I/O subsystems by an assigned rank list.
// Assumes: ack_valid_i is a one-cycle pulse per instruction; reset is synchronous and active low.
module io_intack_arbiter #(
    parameter int                        N        = 4,
    parameter int                        STAT_W   = 8,
    parameter int                        ADDR_W   = 8,
    parameter int                        SEL_W    = 6,
    parameter int                        RIDX_W   = 4,
    parameter int                        WORD_W   = 32,
    parameter int                        IDXW     = (N > 1) ? $clog2(N) : 1,
    parameter logic [N*IDXW-1:0]         RANK_MAP = 8'b01_11_00_10,
    parameter logic [N*ADDR_W-1:0]       SRC_ADDR = 32'h43_42_41_40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        raise_i,
    input  logic [N*STAT_W-1:0] raise_stat_i,
    input  logic                ack_valid_i,
    input  logic [SEL_W-1:0]    ack_sel_i,
    input  logic [RIDX_W-1:0]   ack_ridx_i,
    output logic                rsp_valid_o,
    output logic [1:0]          cc_o,
    output logic                reg_we_o,
    output logic [RIDX_W-1:0]   reg_idx_o,
    output logic [WORD_W-1:0]   reg_wdata_o,
    output logic [N-1:0]        pend_o
);
    logic [N-1:0]        grant;
    logic [N-1:0]        clr;
    logic                any_pend;
    logic [IDXW-1:0]     win_idx;
    logic [N*STAT_W-1:0] stat_all;
    logic                sel_ok;

    // Standard acknowledge only when the selection field is all zero.
    assign sel_ok = (ack_sel_i == '0);
    assign clr    = (ack_valid_i && sel_ok) ? grant : '0;

    intack_pending #(.N(N), .STAT_W(STAT_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise_i (raise_i),
        .stat_i  (raise_stat_i),
        .clr_i   (clr),
        .pend_o  (pend_o),
        .stat_o  (stat_all)
    );

    intack_prio_pick #(.N(N), .IDXW(IDXW), .RANK_MAP(RANK_MAP)) u_pick (
        .pend_i  (pend_o),
        .grant_o (grant),
        .any_o   (any_pend),
        .idx_o   (win_idx)
    );

    intack_resp #(
        .N(N), .IDXW(IDXW), .STAT_W(STAT_W), .ADDR_W(ADDR_W),
        .RIDX_W(RIDX_W), .WORD_W(WORD_W), .SRC_ADDR(SRC_ADDR)
    ) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_valid_i (ack_valid_i),
        .sel_ok_i    (sel_ok),
        .any_i       (any_pend),
        .idx_i       (win_idx),
        .stat_all_i  (stat_all),
        .ridx_i      (ack_ridx_i),
        .rsp_valid_o (rsp_valid_o),
        .cc_o        (cc_o),
        .reg_we_o    (reg_we_o),
        .reg_idx_o   (reg_idx_o),
        .reg_wdata_o (reg_wdata_o)
    );
endmodule

// File: rtl/intack_checker.sv
// Module: intack_checker
// Temporal properties of io_intack_arbiter, attached with bind.
// Assumes: same parameters as the bound instance.
module intack_checker #(
    parameter int N      = 4,
    parameter int SEL_W  = 6,
    parameter int RIDX_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      raise_i,
    input logic              ack_valid_i,
    input logic [SEL_W-1:0]  ack_sel_i,
    input logic [RIDX_W-1:0] ack_ridx_i,
    input logic              rsp_valid_o,
    input logic [1:0]        cc_o,
    input logic              reg_we_o,
    input logic [RIDX_W-1:0] reg_idx_o,
    input logic [N-1:0]      pend_o,
    input logic [N-1:0]      grant
);
    AST_GRANT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~pend_o) == '0)); // R3

    AST_RSP_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_i |=> rsp_valid_o); // R10

    AST_RSP_ONLY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(ack_valid_i)); // R10

    AST_RSVD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_i && ack_sel_i != '0) |=> (cc_o == 2'b11 && !reg_we_o)); // R6

    AST_RSVD_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_i && ack_sel_i != '0 && raise_i == '0) |=> $stable(pend_o)); // R6

    AST_NONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_i && ack_sel_i == '0 && pend_o == '0) |=> (cc_o == 2'b00 && !reg_we_o)); // R9

    AST_ZERO_REG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_i && ack_ridx_i == '0) |=> !reg_we_o); // R7

    AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (rsp_valid_o && cc_o == 2'b01 && reg_idx_o != '0)); // R8

    AST_ACK_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_i && ack_sel_i == '0 && pend_o != '0 && raise_i == '0)
        |=> ($countones(pend_o) == $countones($past(pend_o)) - 1)); // R5
endmodule

bind io_intack_arbiter intack_checker #(.N(N), .SEL_W(SEL_W), .RIDX_W(RIDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .raise_i     (raise_i),
    .ack_valid_i (ack_valid_i),
    .ack_sel_i   (ack_sel_i),
    .ack_ridx_i  (ack_ridx_i),
    .rsp_valid_o (rsp_valid_o),
    .cc_o        (cc_o),
    .reg_we_o    (reg_we_o),
    .reg_idx_o   (reg_idx_o),
    .pend_o      (pend_o),
    .grant       (grant)
);

// File: tb/io_intack_arbiter_test.sv
// Bench: sweeps every pending mask, drains it by acknowledges and checks each reply.
module io_intack_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  raise_i = '0;
    logic [31:0] raise_stat_i = '0;
    logic        ack_valid_i = 1'b0;
    logic [5:0]  ack_sel_i = '0;
    logic [3:0]  ack_ridx_i = '0;
    logic        rsp_valid_o;
    logic [1:0]  cc_o;
    logic        reg_we_o;
    logic [3:0]  reg_idx_o;
    logic [31:0] reg_wdata_o;
    logic [3:0]  pend_o;

    int tests = 0;
    int fails = 0;
    int rank_tab [4] = '{2, 0, 3, 1};
    logic [7:0] stat_model [4];
    logic [3:0] pend_model = '0;

    always #10 clk = ~clk;

    io_intack_arbiter uut (
        .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .raise_stat_i(raise_stat_i),
        .ack_valid_i(ack_valid_i), .ack_sel_i(ack_sel_i), .ack_ridx_i(ack_ridx_i),
        .rsp_valid_o(rsp_valid_o), .cc_o(cc_o), .reg_we_o(reg_we_o),
        .reg_idx_o(reg_idx_o), .reg_wdata_o(reg_wdata_o), .pend_o(pend_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Raise a mask of ports with the given status bytes.
    task automatic raise(input logic [3:0] m, input logic [31:0] st);
        @(negedge clk);
        raise_i = m; raise_stat_i = st;
        for (int i = 0; i < 4; i++) if (m[i]) begin
            pend_model[i] = 1'b1; stat_model[i] = st[i*8 +: 8];
        end
        @(negedge clk);
        raise_i = '0;
        check(pend_o == pend_model, "R2 pend", {28'd0, pend_o}, {28'd0, pend_model});
    endtask

    // Issue one acknowledge and check the reply against the model.
    task automatic ack(input logic [5:0] sel, input logic [3:0] r);
        int win = -1;
        logic [31:0] word;
        for (int k = 3; k >= 0; k--) if (pend_model[rank_tab[k]]) win = rank_tab[k];
        @(negedge clk);
        ack_valid_i = 1'b1; ack_sel_i = sel; ack_ridx_i = r;
        @(negedge clk);
        ack_valid_i = 1'b0;
        check(rsp_valid_o == 1'b1, "R10 valid", {31'd0, rsp_valid_o}, 32'd1);
        if (sel != 0) begin
            check(cc_o == 2'b11, "R6 cc", {30'd0, cc_o}, 32'd3);
            check(!reg_we_o, "R6 we", {31'd0, reg_we_o}, 32'd0);
        end else if (win < 0) begin
            check(cc_o == 2'b00, "R9 cc", {30'd0, cc_o}, 32'd0);
            check(!reg_we_o, "R9 we", {31'd0, reg_we_o}, 32'd0);
        end else begin
            word = {stat_model[win], 16'd0, 8'h40 + 8'(win)};
            pend_model[win] = 1'b0;
            check(cc_o == 2'b01, "R3 cc", {30'd0, cc_o}, 32'd1);
            if (r == 0) begin
                check(!reg_we_o, "R7 we", {31'd0, reg_we_o}, 32'd0);
            end else begin
                check(reg_we_o && reg_idx_o == r, "R8 we/idx", {27'd0, reg_we_o, reg_idx_o}, {27'd0, 1'b1, r});
                check(reg_wdata_o == word, "R3 R4 word", reg_wdata_o, word);
            end
        end
        check(pend_o == pend_model, "R5 pend", {28'd0, pend_o}, {28'd0, pend_model});
        @(negedge clk);
        check(!rsp_valid_o, "R10 one cycle", {31'd0, rsp_valid_o}, 32'd0);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pend_o == 0 && !rsp_valid_o && !reg_we_o, "R1 reset",
              {26'd0, pend_o, rsp_valid_o, reg_we_o}, 32'd0);
        rst_n = 1'b1;
        // R9: empty acknowledge
        ack(6'd0, 4'd5);
        // R3 R4 R5 R8: every mask drained by rank
        for (int m = 1; m < 16; m++) begin
            raise(4'(m), {8'(m*4+3), 8'(m*4+2), 8'(m*4+1), 8'(m*4)});
            for (int k = 0; k < $countones(m); k++) ack(6'd0, 4'(1 + (m + k) % 15));
            ack(6'd0, 4'd1);
        end
        // R6: every reserved selection value leaves the flags alone
        raise(4'b1010, 32'hA1B2C3D4);
        for (int s = 1; s < 64; s++) ack(6'(s), 4'd3);
        // R7: zero register field still acknowledges
        ack(6'd0, 4'd0);
        ack(6'd0, 4'd0);
        ack(6'd0, 4'd0);
        // R11: raise of port 2 during its own acknowledge
        raise(4'b0101, 32'h00_77_00_66);
        @(negedge clk);
        ack_valid_i = 1'b1; ack_sel_i = '0; ack_ridx_i = 4'd9;
        raise_i = 4'b0100; raise_stat_i = 32'h0099_0000;
        @(negedge clk);
        ack_valid_i = 1'b0; raise_i = '0;
        check(reg_wdata_o == 32'h7700_0042, "R11 old reply", reg_wdata_o, 32'h7700_0042);
        check(pend_o == 4'b0101, "R11 pend kept", {28'd0, pend_o}, 32'h5);
        stat_model[2] = 8'h99;
        ack(6'd0, 4'd2);
        ack(6'd0, 4'd2);
        ack(6'd0, 4'd2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule